// File: doc/BRIEF.md
# Extended-Data-Out DRAM I/O Path Controller

This block models, on a fast system clock, the logic that governs the data pins of an extended-data-out dynamic memory. The four active-low strobes (row strobe, column strobe, write enable, output enable) arrive asynchronously. They pass through a synchronizer, and edges are found on the synchronized copies. From these edges the controller decides four things: when the internal I/O path opens and closes, when the output latch takes a new cell value, whether the pins are driven, and which kind of memory cycle is under way.

A small register array stands in for the memory cells. The column address and write data are taken from plain inputs at the moment the controller acts on a strobe edge. The output latch holds its value after the column strobe rises, and the enables only gate the drivers, never the latched data. The block reports its decision through a drive-enable output, the latched data bus and a cycle-kind code.

Top module: `edoIoCtl`

## Requirements
- R1: After reset, the drive enable is 0, the data output is 0 and the cycle-kind code is 0 (idle).
- R2: A row-strobe fall with the column strobe high reports kind 5 with the pins off. A following column-strobe fall with write enable high reports kind 1 (read) and loads the latch with the cell at the address present then. The pins are then driven while output enable is low.
- R3: A high column strobe turns the drivers off, and the latch keeps its data until the next capture.
- R4: A high output enable turns the drivers off and leaves the latch unchanged. Taking output enable low again while the path is open in a read restores driving.
- R5: Write enable low at the column-strobe fall is an early write. It reports kind 2, stores the input data at the address, and keeps the pins off for the whole cycle, even after write enable returns high.
- R6: A write-enable fall while the path is open in a read stores the input data. The drivers stay off while write enable is low. The kind becomes 4 (read-modify-write) if output enable was low at that fall, or 3 (late write) if it was high. Afterwards the pins follow output enable, and the latch keeps the data read earlier.
- R7: A row cycle with no column-strobe fall (row-only refresh) keeps kind 5, leaves the pins off and writes no cell.
- R8: A column-strobe fall while the row strobe is high and the path is closed reports kind 7. It does not open the path, drive the pins or change the latch.
- R9: A row-strobe fall while the column strobe is already low reports kind 6 (column-before-row refresh). It captures nothing, writes nothing, and keeps the pin state and data of the previous cycle.
- R10: A row-strobe rise while the column strobe stays low keeps the path open, the drivers on and the latched data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rasN | input | 1 | Row strobe, active low, asynchronous |
| casN | input | 1 | Column strobe, active low, asynchronous |
| weN | input | 1 | Write enable, active low, asynchronous |
| oeN | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | Cell address, taken at capture or write |
| dIn | input | DATA_W | Write data |
| dOut | output | DATA_W | Output latch contents |
| dOutEn | output | 1 | Pin drive enable (0 means high impedance) |
| cycleKind | output | 3 | Cycle kind: 0 idle, 1 read, 2 early write, 3 late write, 4 read-modify-write, 5 row-only, 6 column-before-row refresh, 7 column-only |

## Verification
Every address is first loaded through an early write with an arithmetic data pattern, then read back with output enable low. This separates address decoding, the capture point and the early-write pin rule. Read cycles toggle output enable and raise the column strobe before the row strobe, which separates the driver gating from the latched value. Late writes with output enable high and low tell late write apart from read-modify-write, and the re-reads show that the latch kept the read data while the cell was updated. Row-only, column-only, column-before-row and hidden-refresh sequences check that these cycles keep or blank the pins as required without touching cells or the latch.

// File: rtl/edoIoPkg.sv
package edoIoPkg;

  typedef enum logic [2:0] {
    KIND_IDLE     = 3'd0,
    KIND_READ     = 3'd1,
    KIND_EARLY_WR = 3'd2,
    KIND_LATE_WR  = 3'd3,
    KIND_RMW      = 3'd4,
    KIND_ROW_ONLY = 3'd5,
    KIND_CBR      = 3'd6,
    KIND_COL_ONLY = 3'd7
  } cycleKind_e;

  typedef struct packed {
    logic capture;
    logic write;
  } dpStrobe_t;

endpackage

// File: rtl/edoSync.sv
module edoSync #(
  parameter int WIDTH     = 4,
  parameter int STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] async,
  output logic [WIDTH-1:0] synced
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RESET_VAL;
    end else begin
      chain[0] <= async;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign synced = chain[STAGES-1];

endmodule

// File: rtl/edoCtl.sv
module edoCtl
  import edoIoPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rasS,
  input  logic       casS,
  input  logic       weS,
  input  logic       oeS,
  output dpStrobe_t  strobe,
  output logic       driveEn,
  output cycleKind_e kind
);

  logic rasP, casP, weP;
  logic pathOpen, allowDrive;
  logic rasFall, casFall, weFall;
  cycleKind_e kindNext;
  logic allowNext, pathNext, driveNext;

  assign rasFall = rasP & ~rasS;
  assign casFall = casP & ~casS;
  assign weFall  = weP & ~weS;

  always_comb begin
    kindNext       = kind;
    allowNext      = allowDrive;
    strobe.capture = 1'b0;
    strobe.write   = 1'b0;
    if (rasFall) begin
      if (!casP) begin
        kindNext = KIND_CBR;
      end else begin
        kindNext  = KIND_ROW_ONLY;
        allowNext = 1'b0;
      end
    end else if (casFall && !rasS && kind != KIND_CBR) begin
      strobe.capture = 1'b1;
      if (!weS) begin
        kindNext     = KIND_EARLY_WR;
        allowNext    = 1'b0;
        strobe.write = 1'b1;
      end else begin
        kindNext  = KIND_READ;
        allowNext = 1'b1;
      end
    end else if (casFall && rasS) begin
      kindNext = KIND_COL_ONLY;
    end else if (weFall && !casS && pathOpen && kind == KIND_READ) begin
      strobe.write = 1'b1;
      kindNext     = oeS ? KIND_LATE_WR : KIND_RMW;
      allowNext    = 1'b1;
    end
  end

  assign pathNext  = ~casS & (pathOpen | (~rasS & (kindNext != KIND_CBR)));
  assign driveNext = pathNext & ~oeS & weS & allowNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasP       <= 1'b1;
      casP       <= 1'b1;
      weP        <= 1'b1;
      pathOpen   <= 1'b0;
      allowDrive <= 1'b0;
      driveEn    <= 1'b0;
      kind       <= KIND_IDLE;
    end else begin
      rasP       <= rasS;
      casP       <= casS;
      weP        <= weS;
      pathOpen   <= pathNext;
      allowDrive <= allowNext;
      driveEn    <= driveNext;
      kind       <= kindNext;
    end
  end

  // R3: a high column strobe leaves the drivers off on the next cycle
  a_r3_cas_high_off: assert property (@(posedge clk) disable iff (!rstN)
    casS |=> !driveEn);
  // R4: a high output enable leaves the drivers off on the next cycle
  a_r4_oe_high_off: assert property (@(posedge clk) disable iff (!rstN)
    oeS |=> !driveEn);
  // R6: write enable low while the column strobe is low blanks the pins
  a_r6_we_low_off: assert property (@(posedge clk) disable iff (!rstN)
    (!casS && !weS) |=> !driveEn);
  // R5: an early write never drives the pins
  a_r5_early_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (kind == KIND_EARLY_WR) |-> !driveEn);
  // R8: a column-only cycle never drives the pins
  a_r8_col_only_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (kind == KIND_COL_ONLY) |-> !driveEn);
  // R9: inside a refresh with the row strobe low, no capture and no write
  a_r9_cbr_no_access: assert property (@(posedge clk) disable iff (!rstN)
    (kind == KIND_CBR && !rasS) |-> (!strobe.capture && !strobe.write));

endmodule

// File: rtl/edoDatapath.sv
module edoDatapath
  import edoIoPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] outLatch
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (strobe.write) begin
      cells[addr] <= dIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outLatch <= '0;
    end else if (strobe.capture) begin
      outLatch <= cells[addr];
    end
  end

  // R4: without a capture the latch keeps its value (enables never touch it)
  a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(outLatch));

endmodule

// File: rtl/edoIoCtl.sv
module edoIoCtl
  import edoIoPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOutEn,
  output logic [2:0]        cycleKind
);

  localparam int NUM_STROBES = 4;

  logic [NUM_STROBES-1:0] strobesS;
  dpStrobe_t  dpCtl;
  cycleKind_e kind;

  edoSync #(.WIDTH(NUM_STROBES), .STAGES(SYNC_STAGES), .RESET_VAL('1)) uSync (
    .clk(clk), .rstN(rstN),
    .async({rasN, casN, weN, oeN}),
    .synced(strobesS)
  );

  edoCtl uCtl (
    .clk(clk), .rstN(rstN),
    .rasS(strobesS[3]), .casS(strobesS[2]), .weS(strobesS[1]), .oeS(strobesS[0]),
    .strobe(dpCtl), .driveEn(dOutEn), .kind(kind)
  );

  edoDatapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(dpCtl),
    .addr(addr), .dIn(dIn), .outLatch(dOut)
  );

  assign cycleKind = kind;

endmodule

// File: tb/edoIoCtl_test.sv
module edoIoCtl_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rasN = 1'b1, casN = 1'b1, weN = 1'b1, oeN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dIn = '0;
  logic [DW-1:0] dOut;
  logic dOutEn;
  logic [2:0] cycleKind;

  int nVec = 0;
  int nBad = 0;
  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] expLatch = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edoIoCtl #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN),
    .addr(addr), .dIn(dIn), .dOut(dOut), .dOutEn(dOutEn), .cycleKind(cycleKind)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic toIdle();
    casN = 1'b1; settle();
    rasN = 1'b1; weN = 1'b1; settle();
  endtask

  task automatic earlyWrite(input int a, input int d);
    addr = a[AW-1:0]; dIn = d[DW-1:0]; oeN = 1'b0; weN = 1'b0;
    rasN = 1'b0; settle();
    casN = 1'b0; settle();
    chk("R5 kind", cycleKind, 2);
    chk("R5 pins off", dOutEn, 0);
    expLatch = model[a];
    model[a] = d[DW-1:0];
    weN = 1'b1; settle();
    chk("R5 pins off after WE high", dOutEn, 0);
    toIdle();
  endtask

  task automatic readCycle(input int a, input bit toggleOe);
    addr = a[AW-1:0]; weN = 1'b1; oeN = 1'b0;
    rasN = 1'b0; settle();
    chk("R2 row kind", cycleKind, 5);
    chk("R2 row pins off", dOutEn, 0);
    casN = 1'b0; settle();
    expLatch = model[a];
    chk("R2 read kind", cycleKind, 1);
    chk("R2 read data", dOut, expLatch);
    chk("R2 read drive", dOutEn, 1);
    if (toggleOe) begin
      oeN = 1'b1; settle();
      chk("R4 oe high off", dOutEn, 0);
      chk("R4 latch kept", dOut, expLatch);
      oeN = 1'b0; settle();
      chk("R4 oe low on", dOutEn, 1);
    end
    casN = 1'b1; settle();
    chk("R3 cas high off", dOutEn, 0);
    chk("R3 edo data kept", dOut, expLatch);
    rasN = 1'b1; settle();
    chk("R3 data after row rise", dOut, expLatch);
  endtask

  task automatic lateWrite(input int a, input int d, input bit oeLowAtWe);
    addr = a[AW-1:0]; dIn = d[DW-1:0]; weN = 1'b1;
    oeN = oeLowAtWe ? 1'b0 : 1'b1;
    rasN = 1'b0; settle();
    casN = 1'b0; settle();
    expLatch = model[a];
    chk("R6 read before write", cycleKind, 1);
    chk("R6 drive follows oe", dOutEn, oeLowAtWe ? 1 : 0);
    weN = 1'b0; settle();
    model[a] = d[DW-1:0];
    chk("R6 kind", cycleKind, oeLowAtWe ? 4 : 3);
    chk("R6 we low off", dOutEn, 0);
    weN = 1'b1; settle();
    chk("R6 after we high", dOutEn, oeLowAtWe ? 1 : 0);
    oeN = 1'b0; settle();
    chk("R6 follows oe low", dOutEn, 1);
    chk("R6 latch keeps read data", dOut, expLatch);
    toIdle();
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset en", dOutEn, 0);
    chk("R1 reset data", dOut, 0);
    chk("R1 reset kind", cycleKind, 0);
    rstN = 1'b1;
    settle();
    chk("R1 idle en", dOutEn, 0);
    chk("R1 idle kind", cycleKind, 0);

    for (int a = 0; a < DEPTH; a++) earlyWrite(a, (a * 29 + 7) & 8'hFF);
    for (int a = 0; a < DEPTH; a++) readCycle(a, a[0]);

    lateWrite(5, 8'hA5, 1'b0);
    lateWrite(6, 8'h3C, 1'b1);
    readCycle(5, 1'b0);
    readCycle(6, 1'b0);

    // R7: row-only refresh with write data present
    addr = 4'd2; dIn = 8'hFF; weN = 1'b1; oeN = 1'b0;
    rasN = 1'b0; settle();
    chk("R7 row-only kind", cycleKind, 5);
    chk("R7 pins off", dOutEn, 0);
    chk("R7 latch kept", dOut, expLatch);
    rasN = 1'b1; settle();
    readCycle(2, 1'b0);

    // R8: column-only cycle
    addr = 4'd9; oeN = 1'b0;
    casN = 1'b0; settle();
    chk("R8 col-only kind", cycleKind, 7);
    chk("R8 pins off", dOutEn, 0);
    chk("R8 latch kept", dOut, expLatch);
    // R9: row strobe falls after column strobe: refresh
    rasN = 1'b0; settle();
    chk("R9 cbr kind", cycleKind, 6);
    chk("R9 pins stay off", dOutEn, 0);
    chk("R9 latch kept", dOut, expLatch);
    toIdle();

    // R10 and R9: hidden refresh after a read
    addr = 4'd11; oeN = 1'b0; weN = 1'b1;
    rasN = 1'b0; settle();
    casN = 1'b0; settle();
    expLatch = model[11];
    chk("R2 hidden read data", dOut, expLatch);
    addr = 4'd12;
    rasN = 1'b1; settle();
    chk("R10 drive kept", dOutEn, 1);
    chk("R10 data kept", dOut, expLatch);
    rasN = 1'b0; settle();
    chk("R9 hidden kind", cycleKind, 6);
    chk("R9 hidden drive kept", dOutEn, 1);
    chk("R9 hidden data kept", dOut, expLatch);
    casN = 1'b1; settle();
    chk("R3 hidden cas high off", dOutEn, 0);
    rasN = 1'b1; settle();

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule